// File: doc/BRIEF.md
# Fractional Open-Circuit MPPT Sequencer

This block schedules open-circuit measurements of an energy-harvesting source and turns each result into a regulation target. Measurements are aligned to a base-time tick. One tick interval is one measurement time. When a measurement is due, the sequencer waits for a tick and halts the boost converter for one full measurement time. It then pulses a start strobe to an external 8-bit ADC, at 10 mV per code, and stores the returned code. The regulation target is the stored code scaled by a programmable fraction, from 42.5 % to 89.0 % in 1.5 % steps. It is truncated to the ADC width so that a digital comparator can use it directly as a threshold.

A measurement can be started in four ways:
- a period counter of 64, 128 or 256 ticks;
- a one-shot host request;
- a jump in the harvest count to more than double, or less than half, of the previous count;
- the first tick after reset.

The controller also keeps a low-light sleep flag, which holds the boost off. It sets when the open-circuit code drops below 29, or when a harvest count falls under a nonzero threshold. It clears when the next measurement begins, or when the host writes a usable open-circuit code.

The controller has four states:
- `ST_IDLE`: waiting for a trigger.
- `ST_HALT`: boost halted for one measurement time.
- `ST_ADC_REQ`: one-cycle ADC start.
- `ST_ADC_WAIT`: waiting for the conversion result.

It has four transitions:
- IDLE→HALT on a tick with a trigger pending.
- HALT→ADC_REQ on the next tick.
- ADC_REQ→ADC_WAIT unconditionally.
- ADC_WAIT→IDLE when `adc_done` is high, which captures the result.

Top module: `mppt_seq`

## Requirements
- R1: After reset `voc_code` is 29, `sleep`, `voc_rdy`, `voc_valid` and `boost_halt` are 0, and `reg_target` is derived from 29 and the current `frac_code` (23 for code 25).
- R2: With `per_en` high, `per_code` values 0, 1 and 2 space successive ADC start pulses by 64, 128 and 256 ticks respectively. `per_code` 3 produces no periodic measurement.
- R3: A measurement begins on a tick. `boost_halt` is then high for exactly one tick interval before the single-cycle `adc_start` pulse, and stays high until `adc_done`. `adc_code` is stored into `voc_code` on the cycle `adc_done` is high.
- R4: `reg_target` equals floor(`voc_code` × (85 + 3 × `frac_code`) / 200) for every 8-bit code and every 5-bit fraction code.
- R5: A one-cycle `force_meas` pulse yields exactly one measurement, whose start strobe appears within two tick intervals. The request does not persist after it is served.
- R6: With `adapt_en` high, a harvest count strictly greater than twice, or strictly less than half, the previous count restarts the period timer and triggers a measurement. Exactly twice or exactly half does not. The first count after reset only seeds the comparison, and `adapt_en` low disables the trigger.
- R7: `sleep` sets when a captured or host-written open-circuit code is below 29, or when a harvest count is below a nonzero `sleep_thr`. While `sleep` is high, `boost_halt` is high.
- R8: `sleep` clears when a measurement starts (scheduled or forced) and when the host writes a code of 29 or more. While asleep, harvest-count jumps trigger nothing.
- R9: `voc_rdy` sets on each capture and clears on `rdy_ack`. `voc_valid` sets on each capture and clears on a host write of the open-circuit code.
- R10: With `per_en` low at reset, no measurement follows reset. With `per_en` high, the first tick after reset starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per measurement time (base time) |
| per_code | input | 2 | Period select: 64/128/256 ticks, 3 = off |
| frac_code | input | 5 | Fraction select, 42.5 % + 1.5 % per step |
| adapt_en | input | 1 | Enable harvest-jump triggering |
| per_en | input | 1 | Enable periodic and post-reset measurement |
| force_meas | input | 1 | Host one-shot measurement request |
| rdy_ack | input | 1 | Host acknowledge that clears `voc_rdy` |
| host_voc_wr | input | 1 | Host write strobe for the open-circuit code |
| host_voc_data | input | 8 | Host-written open-circuit code |
| harv_valid | input | 1 | New harvest count available |
| harv_count | input | 16 | Harvest count |
| sleep_thr | input | 8 | Harvest-count sleep threshold, 0 = off |
| adc_done | input | 1 | ADC conversion complete |
| adc_code | input | 8 | ADC conversion result |
| boost_halt | output | 1 | Halt the boost converter |
| adc_start | output | 1 | One-cycle ADC start |
| voc_code | output | 8 | Stored open-circuit code |
| reg_target | output | 8 | Source regulation target code |
| sleep | output | 1 | Low-light sleep active |
| voc_rdy | output | 1 | New measurement since last acknowledge |
| voc_valid | output | 1 | Stored code came from a measurement |

## Verification
A wrong state in the sequencer shows up at `adc_start` and `boost_halt`. A lost or duplicated trigger appears as a start-pulse spacing other than the period, or as an extra or missing pulse, within two tick intervals of the cause. A corrupted period counter shows up as the wrong tick count between pulses in the very next period. A stale reference count or sleep flag is exposed by the next harvest pulse or host write: the result shows in `sleep` one cycle later, or as a start pulse that is present or absent within two ticks. Target arithmetic errors show in `reg_target` one cycle after the write that exposes them, and the bench sweeps every code and fraction combination for this.

// File: rtl/mppt_seq_pkg.sv
package mppt_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_HALT     = 2'd1,
        ST_ADC_REQ  = 2'd2,
        ST_ADC_WAIT = 2'd3
    } seq_state_t;

    localparam int VOC_W        = 8;
    localparam int FRAC_W       = 5;
    localparam int VOC_INIT     = 29;
    localparam int FRAC_OFFSET  = 85;   // 42.5 % in half-percent units
    localparam int FRAC_STEP    = 3;    // 1.5 %
    localparam int FRAC_DIVISOR = 200;  // 100 % in half-percent units
endpackage

// File: rtl/mppt_period_timer.sv
module mppt_period_timer #(
    parameter int PER_BASE = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       per_en,
    input  logic [1:0] per_code,
    input  logic       restart,
    output logic       expire
);
    localparam int CW = $clog2(PER_BASE * 4) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;
    logic          active;

    always_comb begin
        unique case (per_code)
            2'd0:    last_q = CW'(PER_BASE - 1);
            2'd1:    last_q = CW'(2 * PER_BASE - 1);
            default: last_q = CW'(4 * PER_BASE - 1);
        endcase
    end

    assign active = per_en && (per_code != 2'd3);
    assign expire = active && tick && (cnt_q == last_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !active) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != last_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mppt_harvest_watch.sv
module mppt_harvest_watch #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          harv_valid,
    input  logic [HW-1:0] harv_count,
    input  logic          adapt_en,
    input  logic          asleep,
    output logic          jump
);
    logic [HW-1:0] ref_q;
    logic          have_ref_q;
    logic          above, below;

    assign above = {1'b0, harv_count} > {ref_q, 1'b0};
    assign below = {harv_count, 1'b0} < {1'b0, ref_q};
    assign jump  = harv_valid && have_ref_q && adapt_en && !asleep && (above || below);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q      <= '0;
            have_ref_q <= 1'b0;
        end else if (harv_valid) begin
            ref_q      <= harv_count;
            have_ref_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mppt_target.sv
module mppt_target
    import mppt_seq_pkg::*;
#(
    parameter int AW = VOC_W,
    parameter int FW = FRAC_W
) (
    input  logic [AW-1:0] voc,
    input  logic [FW-1:0] frac,
    output logic [AW-1:0] target
);
    localparam int CW = 8;
    localparam int PW = AW + CW;

    logic [CW-1:0] coef;
    logic [PW-1:0] prod;
    logic [PW-1:0] quot;

    assign coef   = CW'(FRAC_OFFSET) + CW'(FRAC_STEP) * CW'(frac);
    assign prod   = PW'(voc) * PW'(coef);
    assign quot   = prod / PW'(FRAC_DIVISOR);
    assign target = quot[AW-1:0];
endmodule

// File: rtl/mppt_seq.sv
module mppt_seq
    import mppt_seq_pkg::*;
#(
    parameter int PER_BASE = 64,
    parameter int HW       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       per_code,
    input  logic [FRAC_W-1:0] frac_code,
    input  logic             adapt_en,
    input  logic             per_en,
    input  logic             force_meas,
    input  logic             rdy_ack,
    input  logic             host_voc_wr,
    input  logic [VOC_W-1:0] host_voc_data,
    input  logic             harv_valid,
    input  logic [HW-1:0]    harv_count,
    input  logic [VOC_W-1:0] sleep_thr,
    input  logic             adc_done,
    input  logic [VOC_W-1:0] adc_code,
    output logic             boost_halt,
    output logic             adc_start,
    output logic [VOC_W-1:0] voc_code,
    output logic [VOC_W-1:0] reg_target,
    output logic             sleep,
    output logic             voc_rdy,
    output logic             voc_valid
);
    localparam logic [VOC_W-1:0] SLEEP_CODE = VOC_W'(VOC_INIT);

    seq_state_t       state_q, state_d;
    logic             force_pend_q, adapt_pend_q, init_pend_q;
    logic             expire, jump, trig, capture, harv_low, measuring;
    logic [VOC_W-1:0] voc_q;
    logic             sleep_q, rdy_q, valid_q;

    mppt_period_timer #(.PER_BASE(PER_BASE)) timer_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .per_en(per_en),
        .per_code(per_code), .restart(trig || jump), .expire(expire)
    );

    mppt_harvest_watch #(.HW(HW)) watch_i (
        .clk(clk), .rst_n(rst_n), .harv_valid(harv_valid), .harv_count(harv_count),
        .adapt_en(adapt_en), .asleep(sleep_q), .jump(jump)
    );

    mppt_target #(.AW(VOC_W), .FW(FRAC_W)) target_i (
        .voc(voc_q), .frac(frac_code), .target(reg_target)
    );

    assign trig = (state_q == ST_IDLE) && tick &&
                  (expire || force_pend_q || adapt_pend_q || (init_pend_q && per_en));
    assign capture  = (state_q == ST_ADC_WAIT) && adc_done;
    assign harv_low = harv_valid && (sleep_thr != '0) && (harv_count < HW'(sleep_thr));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (trig)     state_d = ST_HALT;
            ST_HALT:     if (tick)     state_d = ST_ADC_REQ;
            ST_ADC_REQ:                state_d = ST_ADC_WAIT;
            ST_ADC_WAIT: if (adc_done) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        measuring  = (state_q != ST_IDLE);
        adc_start  = (state_q == ST_ADC_REQ);
        boost_halt = measuring || sleep_q;
        voc_code   = voc_q;
        sleep      = sleep_q;
        voc_rdy    = rdy_q;
        voc_valid  = valid_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_pend_q <= 1'b0;
            adapt_pend_q <= 1'b0;
            init_pend_q  <= 1'b1;
            voc_q        <= SLEEP_CODE;
            sleep_q      <= 1'b0;
            rdy_q        <= 1'b0;
            valid_q      <= 1'b0;
        end else begin
            force_pend_q <= force_meas | (force_pend_q & ~trig);
            adapt_pend_q <= jump | (adapt_pend_q & ~trig);
            if (tick) init_pend_q <= 1'b0;

            if (capture)          voc_q <= adc_code;
            else if (host_voc_wr) voc_q <= host_voc_data;

            if (capture)          sleep_q <= (adc_code < SLEEP_CODE);
            else if (host_voc_wr) sleep_q <= (host_voc_data < SLEEP_CODE);
            else if (trig)        sleep_q <= 1'b0;
            else if (harv_low)    sleep_q <= 1'b1;

            if (capture)      rdy_q <= 1'b1;
            else if (rdy_ack) rdy_q <= 1'b0;

            if (capture)          valid_q <= 1'b1;
            else if (host_voc_wr) valid_q <= 1'b0;
        end
    end

    AST_START_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> boost_halt); // R3
    AST_CAPTURE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (voc_code == $past(adc_code)) && voc_rdy && voc_valid); // R9
    AST_LOW_WRITE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_voc_wr && !capture && (host_voc_data < SLEEP_CODE)) |=> sleep); // R7
    AST_START_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !host_voc_wr) |=> !sleep); // R8
    AST_TARGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        reg_target <= voc_code); // R4
endmodule

// File: tb/mppt_seq_tb.sv
module mppt_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TK         = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] per_code = 2'd3;
    logic [4:0] frac_code = 5'd25;
    logic       adapt_en = 1'b0, per_en = 1'b0, force_meas = 1'b0, rdy_ack = 1'b0;
    logic       host_voc_wr = 1'b0;
    logic [7:0] host_voc_data = '0;
    logic       harv_valid = 1'b0;
    logic [15:0] harv_count = '0;
    logic [7:0] sleep_thr = '0;
    logic       adc_done = 1'b0;
    logic [7:0] adc_code = '0;
    logic       boost_halt, adc_start, sleep, voc_rdy, voc_valid;
    logic [7:0] voc_code, reg_target;

    int n_cmp = 0, n_bad = 0;
    int tdiv = 0, tick_num = 0, starts = 0, last_tick = 0, adc_cnt = 0;
    int halt_run = 0, halt_len = 0;
    bit sleep_at_start = 0;
    logic [7:0] adc_val = 8'd100;

    mppt_seq dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // tick generator, ADC model and monitor, all at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv = 0; tick = 1'b0; adc_done = 1'b0; adc_cnt = 0;
        end else begin
            tick = (tdiv == TK-1);
            if (tick) tick_num++;
            tdiv = (tdiv + 1) % TK;
            adc_done = 1'b0;
            if (adc_cnt > 0) begin
                adc_cnt--;
                if (adc_cnt == 0) begin adc_done = 1'b1; adc_code = adc_val; end
            end
            if (adc_start) begin
                starts++; last_tick = tick_num; adc_cnt = 3;
                halt_len = halt_run; sleep_at_start = sleep;
            end
            if (boost_halt && !adc_start) halt_run++;
            else if (!boost_halt) halt_run = 0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk); host_voc_wr = 1'b1; host_voc_data = v;
        @(negedge clk); host_voc_wr = 1'b0;
    endtask

    task automatic harv(input int c);
        @(negedge clk); harv_valid = 1'b1; harv_count = 16'(c);
        @(negedge clk); harv_valid = 1'b0;
        cyc(3*TK + 8);
    endtask

    task automatic force_pulse;
        @(negedge clk); force_meas = 1'b1;
        @(negedge clk); force_meas = 1'b0;
        cyc(3*TK + 8);
    endtask

    task automatic wait_starts(input int n);
        while (starts < n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s, t1;
        cyc(3); rst_n = 1'b1; cyc(1);
        // R1 reset state
        chk(voc_code == 8'd29, "R1 voc", voc_code, 29);
        chk(reg_target == 8'd23, "R1 target", reg_target, 23);
        chk({sleep, voc_rdy, voc_valid, boost_halt} == 4'b0, "R1 flags",
            {sleep, voc_rdy, voc_valid, boost_halt}, 0);
        cyc(5*TK);
        chk(starts == 0, "R10 no post-reset measurement", starts, 0);

        // R4 / R7 exhaustive target and sleep sweep via host writes
        for (int f = 0; f < 32; f++) begin
            frac_code = 5'(f);
            for (int v = 0; v < 256; v++) begin
                host_write(8'(v));
                chk(reg_target == 8'((v * (85 + 3*f)) / 200), "R4 target",
                    reg_target, (v * (85 + 3*f)) / 200);
                chk(sleep == (v < 29), "R7 R8 sleep on write", sleep, v < 29);
            end
        end
        chk(starts == 0, "R10 no measurement while disabled", starts, 0);
        frac_code = 5'd25;
        host_write(8'd60);

        // R2 period spacing
        per_en = 1'b1;
        for (int c = 0; c < 3; c++) begin
            per_code = 2'(c);
            s = starts;
            wait_starts(s + 1); t1 = last_tick;
            wait_starts(s + 2);
            chk(last_tick - t1 == (64 << c), "R2 period", last_tick - t1, 64 << c);
        end
        per_code = 2'd3;
        cyc(10*TK);
        s = starts; cyc(300*TK);
        chk(starts == s, "R2 code 3 off", starts - s, 0);

        // R5 / R3 / R9 forced measurement
        adc_val = 8'd123;
        rdy_ack = 1'b1; cyc(1); rdy_ack = 1'b0;
        s = starts;
        force_pulse();
        chk(starts == s + 1, "R5 force one measurement", starts - s, 1);
        chk(halt_len == TK, "R3 halt one measurement time", halt_len, TK);
        chk(voc_code == 8'd123, "R3 capture", voc_code, 123);
        chk(reg_target == 8'((123 * 160) / 200), "R4 measured target", reg_target, (123*160)/200);
        chk(voc_rdy && voc_valid, "R9 flags set", {voc_rdy, voc_valid}, 3);
        chk(!boost_halt, "R3 halt released", boost_halt, 0);
        cyc(30*TK);
        chk(starts == s + 1, "R5 force self-clears", starts - s, 1);
        rdy_ack = 1'b1; cyc(1); rdy_ack = 1'b0; cyc(1);
        chk(!voc_rdy && voc_code == 8'd123, "R9 ack clears ready", voc_rdy, 0);
        host_write(8'd60);
        chk(!voc_valid && voc_code == 8'd60, "R9 write clears valid", voc_valid, 0);

        // R6 adaptive triggering
        adc_val = 8'd100; adapt_en = 1'b1;
        s = starts; harv(100);
        chk(starts == s, "R6 first count seeds", starts - s, 0);
        s = starts; harv(150);
        chk(starts == s, "R6 small change", starts - s, 0);
        s = starts; harv(301);
        chk(starts == s + 1, "R6 above double", starts - s, 1);
        s = starts; harv(149);
        chk(starts == s + 1, "R6 below half", starts - s, 1);
        s = starts; harv(298);
        chk(starts == s, "R6 exactly double", starts - s, 0);
        s = starts; harv(149);
        chk(starts == s, "R6 exactly half", starts - s, 0);
        adapt_en = 1'b0;
        s = starts; harv(20);
        chk(starts == s, "R6 disabled", starts - s, 0);

        // R7 / R8 sleep via threshold, suppression, exits
        sleep_thr = 8'd50;
        harv(40);
        chk(sleep && boost_halt, "R7 count below threshold", sleep, 1);
        adapt_en = 1'b1;
        s = starts; harv(200);
        chk(starts == s && sleep, "R8 jump ignored asleep", starts - s, 0);
        adapt_en = 1'b0; sleep_thr = 8'd0;
        force_pulse();
        chk(!sleep_at_start, "R8 sleep cleared at start", sleep_at_start, 0);
        chk(!sleep && voc_code == 8'd100, "R8 awake after good measure", sleep, 0);
        adc_val = 8'd20;
        force_pulse();
        chk(sleep && voc_code == 8'd20, "R7 low measurement sleeps", sleep, 1);
        adc_val = 8'd100; per_code = 2'd0;
        s = starts; wait_starts(s + 1);
        chk(!sleep_at_start, "R8 scheduled measurement wakes", sleep_at_start, 0);
        cyc(10);
        chk(!sleep, "R8 awake after scheduled", sleep, 0);

        // R10 post-reset measurement with periodic enable
        per_code = 2'd3;
        @(negedge clk); rst_n = 1'b0; cyc(2); rst_n = 1'b1;
        s = starts; cyc(3*TK);
        chk(starts == s + 1, "R10 measurement after reset", starts - s, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule